// File: doc/BRIEF.md
# Dual-Cell Boundary Scan Register with Signature and Pattern Modes

This block is the boundary-scan register that sits between a bidirectional bus transceiver core and its A-side and B-side pins. Each bit position has two scan cells: one on the A pin and one on the B pin. Test data can therefore be observed or forced on either bus without touching the other. The test access controller and the instruction register stay outside the block. They reach it through one-cycle strobes (capture, shift, update, run) and a three-bit mode code. Every action is clocked by the test clock `tck`, and the reset is synchronous and active high.

Beyond sampling and forcing pins, the same register can be reconfigured in three ways. It can compress pin inputs into a signature using an internal-feedback LFSR. It can free-run as a pseudo-random pattern source whose state is driven onto the pins. It can also split into two halves: an 8-bit signature compressor on the A bus, and a binary counter on the B bus whose count is driven out, for example as memory addresses. A self-test mode copies the update latches back into the scan cells, so the chain can be checked without the pins.

The register layout is fixed as follows. `cells[2W-1:W]` hold the A cells, with A bit i at `cells[W+i]`, and `cells[W-1:0]` hold the B cells. Mode codes are: 0 normal, 1 sample, 2 force (extest), 3 signature, 4 pattern, 5 signature-plus-count, 6 self-test, and 7 behaves like normal.

Top module: `dual_bscan_reg`

## Requirements
- R1: While `rst` is sampled high at a rising `tck` edge, the cells, the update latches, `a_drv` and `b_drv` clear to zero. `tdo` clears to zero on the falling edge while `rst` is high.
- R2: With `shift_en` and no capture, `tdi` enters `cells[2W-1]` and every other cell takes the value of the cell above it. The chain thus runs from TDI through the A cells and then the B cells. `tdo` takes `cells[0]` on each falling edge of `tck`.
- R3: With `capture_en`, the cells load `{pin_a, pin_b}` in every mode except self-test (6). In self-test they load the update latches instead.
- R4: With `update_en`, the update latches load the cells' value from before the edge. Update works regardless of the other strobes.
- R5: In normal (0), sample (1) and code 7, `a_drv`/`b_drv` register `core_a`/`core_b` one edge later, so sampling never disturbs the datapath.
- R6: In extest (2), signature (3) and self-test (6), `a_drv`/`b_drv` register the A and B halves of the update latches one edge later.
- R7: Signature mode (3) with `run_en` replaces the cells with `gal(cells) ^ {pin_a, pin_b}`. Here `gal(s) = (s>>1) ^ (s[0] ? POLY_FULL : 0)`, and the default `POLY_FULL` is 16'hB400, i.e. x^16+x^14+x^13+x^11+1.
- R8: Pattern mode (4) with `run_en` replaces the cells with `gal(cells)`. In mode 4, `{a_drv, b_drv}` register the cells one edge later, so a seed of 16'h0001 gives 16'hB400 after one step.
- R9: Mode 5 with `run_en` sets the A half to `galh(A) ^ pin_a`, where `galh` uses `POLY_HALF`, default 8'hB8. It also increments the B half by one, wrapping from all ones to zero. In mode 5, `a_drv` shows the A update latches and `b_drv` shows the B cells.
- R10: Capture has priority over shift, and shift has priority over run. `run_en` leaves the cells unchanged in modes 0, 1, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Decoded instruction mode code |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| run_en | input | 1 | Run/idle enable for signature, pattern and count steps |
| tdi | input | 1 | Serial test data in |
| core_a | input | W | Transceiver core value for the A pins |
| core_b | input | W | Transceiver core value for the B pins |
| pin_a | input | W | Observed A pin values |
| pin_b | input | W | Observed B pin values |
| a_drv | output | W | Registered drive value for the A pins |
| b_drv | output | W | Registered drive value for the B pins |
| tdo | output | 1 | Serial test data out, changes on falling tck |

## Verification
The bench targets several specific mistakes:
- Simultaneous capture and shift strobes catch a wrong priority, which would leave the cells shifted rather than loaded from the pins.
- Seeding the chain with 16'h0001 and stepping the pattern source once catches a wrong tap mask or shift direction, which would show a value other than 16'hB400 on the pins.
- Loading 16'h00FF and counting once catches a count that fails to wrap, carries into the A half, or drives the wrong half onto `b_drv`.
- A self-test capture with conflicting pin values catches a design that reads the pins instead of the update latches.
- Random cycles compare every output against a reference model. They catch a TDO sampled on the wrong edge or a drive value registered one cycle early or late.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_SAMPLE = 3'd1,
    MD_EXTEST = 3'd2,
    MD_PSA    = 3'd3,
    MD_PRPG   = 3'd4,
    MD_PSACNT = 3'd5,
    MD_SELF   = 3'd6,
    MD_SPARE  = 3'd7
  } bsr_mode_e;
endpackage

// File: rtl/bsr_cells.sv
module bsr_cells
  import bsr_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 2 * W,
  parameter logic [N-1:0] POLY_FULL = 16'hB400,
  parameter logic [W-1:0] POLY_HALF = 8'hB8
) (
  input  logic         tck,
  input  logic         rst,
  input  bsr_mode_e    mode,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         run_en,
  input  logic         tdi,
  input  logic [W-1:0] pin_a,
  input  logic [W-1:0] pin_b,
  input  logic [N-1:0] upd,
  output logic [N-1:0] cells
);
  // Galois (internal feedback) right-shift step over the full chain
  function automatic logic [N-1:0] step_full(input logic [N-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY_FULL : '0);
  endfunction

  // Galois step over one half, used by the split compress/count mode
  function automatic logic [W-1:0] step_half(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY_HALF : '0);
  endfunction

  logic [N-1:0] run_next;

  always_comb begin
    run_next = cells;
    case (mode)
      MD_PSA:    run_next = step_full(cells) ^ {pin_a, pin_b};
      MD_PRPG:   run_next = step_full(cells);
      MD_PSACNT: run_next = {step_half(cells[N-1:W]) ^ pin_a,
                             cells[W-1:0] + W'(1)};
      default:   run_next = cells;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst)
      cells <= '0;
    else if (capture_en)
      cells <= (mode == MD_SELF) ? upd : {pin_a, pin_b};
    else if (shift_en)
      cells <= {tdi, cells[N-1:1]};
    else if (run_en)
      cells <= run_next;
  end
endmodule

// File: rtl/bsr_update.sv
module bsr_update #(
  parameter int N = 16
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         update_en,
  input  logic [N-1:0] cells,
  output logic [N-1:0] upd
);
  always_ff @(posedge tck) begin
    if (rst)
      upd <= '0;
    else if (update_en)
      upd <= cells;
  end
endmodule

// File: rtl/bsr_drive.sv
module bsr_drive
  import bsr_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 2 * W
) (
  input  logic         tck,
  input  logic         rst,
  input  bsr_mode_e    mode,
  input  logic [W-1:0] core_a,
  input  logic [W-1:0] core_b,
  input  logic [N-1:0] cells,
  input  logic [N-1:0] upd,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_drv
);
  always_ff @(posedge tck) begin
    if (rst) begin
      a_drv <= '0;
      b_drv <= '0;
    end else begin
      case (mode)
        MD_EXTEST, MD_PSA, MD_SELF: begin
          a_drv <= upd[N-1:W];
          b_drv <= upd[W-1:0];
        end
        MD_PRPG: begin
          a_drv <= cells[N-1:W];
          b_drv <= cells[W-1:0];
        end
        MD_PSACNT: begin
          a_drv <= upd[N-1:W];
          b_drv <= cells[W-1:0];
        end
        default: begin
          a_drv <= core_a;
          b_drv <= core_b;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsr_tdo.sv
module bsr_tdo (
  input  logic tck,
  input  logic rst,
  input  logic last_cell,
  output logic tdo
);
  always_ff @(negedge tck) begin
    if (rst)
      tdo <= 1'b0;
    else
      tdo <= last_cell;
  end
endmodule

// File: rtl/dual_bscan_reg.sv
module dual_bscan_reg
  import bsr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [2*W-1:0] POLY_FULL = 16'hB400,
  parameter logic [W-1:0]   POLY_HALF = 8'hB8
) (
  input  logic         tck,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         run_en,
  input  logic         tdi,
  input  logic [W-1:0] core_a,
  input  logic [W-1:0] core_b,
  input  logic [W-1:0] pin_a,
  input  logic [W-1:0] pin_b,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_drv,
  output logic         tdo
);
  localparam int N = 2 * W;

  bsr_mode_e    mode_e;
  logic [N-1:0] cells;
  logic [N-1:0] upd;

  assign mode_e = bsr_mode_e'(mode);

  bsr_cells #(.W(W), .N(N), .POLY_FULL(POLY_FULL), .POLY_HALF(POLY_HALF)) u_cells (
    .tck(tck), .rst(rst), .mode(mode_e), .capture_en(capture_en),
    .shift_en(shift_en), .run_en(run_en), .tdi(tdi),
    .pin_a(pin_a), .pin_b(pin_b), .upd(upd), .cells(cells)
  );

  bsr_update #(.N(N)) u_update (
    .tck(tck), .rst(rst), .update_en(update_en), .cells(cells), .upd(upd)
  );

  bsr_drive #(.W(W), .N(N)) u_drive (
    .tck(tck), .rst(rst), .mode(mode_e), .core_a(core_a), .core_b(core_b),
    .cells(cells), .upd(upd), .a_drv(a_drv), .b_drv(b_drv)
  );

  bsr_tdo u_tdo (
    .tck(tck), .rst(rst), .last_cell(cells[0]), .tdo(tdo)
  );
endmodule

// File: rtl/dual_bscan_chk.sv
module dual_bscan_chk
  import bsr_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 2 * W
) (
  input logic         tck,
  input logic         rst,
  input logic [2:0]   mode,
  input logic         capture_en,
  input logic         shift_en,
  input logic         update_en,
  input logic         run_en,
  input logic         tdi,
  input logic [W-1:0] core_a,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] b_drv,
  input logic         tdo,
  input logic [N-1:0] cells,
  input logic [N-1:0] upd
);
  // R2
  shift_move_chk: assert property (@(posedge tck) disable iff (rst)
    (shift_en && !capture_en) |=>
      (cells[N-1] == $past(tdi) && cells[N-2:0] == $past(cells[N-1:1])));

  // R2
  tdo_follow_chk: assert property (@(posedge tck) disable iff (rst)
    tdo == cells[0]);

  // R4
  update_load_chk: assert property (@(posedge tck) disable iff (rst)
    update_en |=> upd == $past(cells));

  // R5
  normal_pass_chk: assert property (@(posedge tck) disable iff (rst)
    (mode == MD_NORMAL) |=> a_drv == $past(core_a));

  // R6
  extest_force_chk: assert property (@(posedge tck) disable iff (rst)
    (mode == MD_EXTEST) |=>
      (a_drv == $past(upd[N-1:W]) && b_drv == $past(upd[W-1:0])));

  // R9
  count_step_chk: assert property (@(posedge tck) disable iff (rst)
    (run_en && !capture_en && !shift_en && mode == MD_PSACNT) |=>
      cells[W-1:0] == $past(cells[W-1:0]) + W'(1));

  // R10
  run_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (run_en && !capture_en && !shift_en && mode == MD_EXTEST) |=>
      $stable(cells));
endmodule

bind dual_bscan_reg dual_bscan_chk #(.W(W)) u_chk (
  .tck(tck), .rst(rst), .mode(mode), .capture_en(capture_en),
  .shift_en(shift_en), .update_en(update_en), .run_en(run_en), .tdi(tdi),
  .core_a(core_a), .a_drv(a_drv), .b_drv(b_drv), .tdo(tdo),
  .cells(cells), .upd(upd)
);

// File: tb/dual_bscan_reg_tb.sv
module dual_bscan_reg_tb;
  localparam int W = 8;
  localparam int N = 16;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic         rst, capture_en, shift_en, update_en, run_en, tdi;
  logic [2:0]   mode;
  logic [W-1:0] core_a, core_b, pin_a, pin_b, a_drv, b_drv;
  logic         tdo;

  dual_bscan_reg #(.W(W)) u_dut (
    .tck(tck), .rst(rst), .mode(mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .run_en(run_en), .tdi(tdi),
    .core_a(core_a), .core_b(core_b), .pin_a(pin_a), .pin_b(pin_b),
    .a_drv(a_drv), .b_drv(b_drv), .tdo(tdo)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0] m_cells, m_upd;
  logic [W-1:0] e_a, e_b;
  logic         e_tdo;

  function automatic logic [N-1:0] gal16(input logic [N-1:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [W-1:0] gal8(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    capture_en = 0; shift_en = 0; update_en = 0; run_en = 0; tdi = 0;
  endtask

  // One tck cycle: predict from the requirements, then compare after the falling edge
  task automatic cyc();
    string tag;
    logic [N-1:0] nc;
    if (rst) begin
      tag = "R1"; e_a = '0; e_b = '0; m_cells = '0; m_upd = '0;
    end else begin
      case (mode)
        3'd2, 3'd3, 3'd6: begin e_a = m_upd[N-1:W];   e_b = m_upd[W-1:0];   end
        3'd4:             begin e_a = m_cells[N-1:W]; e_b = m_cells[W-1:0]; end
        3'd5:             begin e_a = m_upd[N-1:W];   e_b = m_cells[W-1:0]; end
        default:          begin e_a = core_a;         e_b = core_b;         end
      endcase
      nc = m_cells;
      if (capture_en) begin
        nc = (mode == 3'd6) ? m_upd : {pin_a, pin_b}; tag = "R3";
      end else if (shift_en) begin
        nc = {tdi, m_cells[N-1:1]}; tag = "R2";
      end else if (run_en) begin
        case (mode)
          3'd3: begin nc = gal16(m_cells) ^ {pin_a, pin_b}; tag = "R7"; end
          3'd4: begin nc = gal16(m_cells); tag = "R8"; end
          3'd5: begin nc = {gal8(m_cells[N-1:W]) ^ pin_a, m_cells[W-1:0] + 8'd1}; tag = "R9"; end
          default: tag = "R10";
        endcase
      end else if (update_en) tag = "R4";
      else if (mode inside {3'd0, 3'd1, 3'd7}) tag = "R5";
      else tag = "R6";
      if (update_en) m_upd = m_cells;
      m_cells = nc;
    end
    e_tdo = m_cells[0];
    @(negedge tck); #1;
    chk(tag, {15'd0, a_drv, b_drv, tdo}, {15'd0, e_a, e_b, e_tdo});
  endtask

  task automatic shift_word(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) begin
      idle_inputs(); shift_en = 1; tdi = v[i]; cyc();
    end
    idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; mode = 3'd0; idle_inputs();
    core_a = 8'h11; core_b = 8'h22; pin_a = 8'h33; pin_b = 8'h44;
    repeat (3) cyc();
    // R1 reset state at the ports
    chk("R1", {15'd0, a_drv, b_drv, tdo}, 32'd0);
    rst = 0;
    cyc();

    // R2 seed via shift, R8 one pattern step from 0x0001
    mode = 3'd4;
    shift_word(16'h0001);
    chk("R2", {31'd0, tdo}, 32'd1);
    run_en = 1; cyc(); idle_inputs(); cyc();
    chk("R8", {16'd0, a_drv, b_drv}, 32'h0000B400);

    // R9 count wraps from all ones to zero
    mode = 3'd5; pin_a = 8'h00;
    shift_word(16'h00FF);
    run_en = 1; cyc(); idle_inputs(); cyc();
    chk("R9", {24'd0, b_drv}, 32'h00);

    // R3 self-test capture takes the update latches, not the pins
    shift_word(16'h00FF);
    update_en = 1; cyc(); idle_inputs();
    mode = 3'd6; pin_a = 8'h5A; pin_b = 8'hA5; capture_en = 1; cyc(); idle_inputs();
    mode = 3'd4; cyc(); cyc();
    chk("R3", {16'd0, a_drv, b_drv}, 32'h000000FF);

    // R10 capture beats shift and run; then R6 forces the captured value
    mode = 3'd2; pin_a = 8'h3C; pin_b = 8'hC3;
    capture_en = 1; shift_en = 1; run_en = 1; tdi = 1; cyc(); idle_inputs();
    update_en = 1; cyc(); idle_inputs(); cyc();
    chk("R10", {16'd0, a_drv, b_drv}, 32'h00003CC3);

    // R5 sample mode passes core values
    mode = 3'd1; core_a = 8'h9E; core_b = 8'h61; cyc(); cyc();
    chk("R5", {16'd0, a_drv, b_drv}, 32'h00009E61);

    // Random mix, every cycle checked against the model (R2..R10)
    for (int k = 0; k < 3000; k++) begin
      int sel;
      idle_inputs();
      mode   = 3'($urandom % 8);
      core_a = 8'($urandom); core_b = 8'($urandom);
      pin_a  = 8'($urandom); pin_b  = 8'($urandom);
      tdi    = 1'($urandom);
      sel    = int'($urandom % 7);
      case (sel)
        0: capture_en = 1;
        1, 2: shift_en = 1;
        3, 4: run_en = 1;
        5: begin capture_en = 1; shift_en = 1; run_en = 1; end
        default: ;
      endcase
      update_en = (($urandom % 4) == 0);
      if (($urandom % 200) == 0) rst = 1;
      cyc();
      rst = 0;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule